// File: doc/BRIEF.md
# Event Length Gate with Minimum Discard and Maximum Truncation

This block sits between an event buffer of a front-end and the link that carries its data away. Words arrive as a stream in which the first word of an event carries a start marker and the final word carries an end marker. The block counts the words of every event. It decides at the end marker whether the event is passed on. An event that holds fewer words than a programmed lower bound is removed entirely. This is useful for suppressing events that carry only framing and a reference measurement. An event that holds more words than a programmed upper bound is shortened to that bound. The words beyond the bound are accepted and thrown away, and the event is flagged as shortened.

Accepted words are written into a local store, which maps onto block RAM. Words of an event that is still open are held there without being committed. When the event closes short, the write pointer simply falls back to the last commit point. A kept event leaves a small descriptor (stored length and shortened flag). The read side uses these descriptors to replay the words on a valid/ready output. The shortened flag appears with the last word of the event. Two wrapping counters report how many events were dropped and how many were shortened.

The upper bound is limited to the store depth. A bound of zero, or a bound larger than the store, behaves as a bound equal to the store depth. A lower bound of zero turns discarding off. The store depth must be a power of two.

Top module: `event_size_filter`

## Requirements
- R1: While and right after the synchronous reset, out_valid is 0, discard_count and trunc_count are 0 and in_ready is 1.
- R2: Every kept event appears on the output with its words in arrival order and events in arrival order. out_last is 1 on the final output word of each event and 0 on all other words.
- R3: When min_words is not 0, an event of N < min_words words is accepted completely and produces no output word, and discard_count rises by exactly one.
- R4: An event of N > L words (L as in R6) yields only its first L words. The remaining words are accepted and dropped, out_trunc is 1 on the last forwarded word of that event (0 everywhere else), and trunc_count rises by exactly one.
- R5: With min_words = 0 no event is discarded; a single-word event (start and end marker on the same word) is forwarded as one word with out_last = 1.
- R6: The effective limit L equals max_words for 1 ≤ max_words ≤ DEPTH, and equals DEPTH when max_words is 0 or greater than DEPTH.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data, out_last and out_trunc stay unchanged on the next cycle.
- R8: Boundaries: an event of exactly min_words words is kept, and an event of exactly L words is forwarded completely with out_trunc = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| min_words | input | CFG_W | Lower bound; events shorter than this are dropped, 0 disables |
| max_words | input | CFG_W | Upper bound on forwarded words per event, 0 means store depth |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | DATA_W | Input word |
| in_sop | input | 1 | Input word is the first of its event |
| in_eop | input | 1 | Input word is the last of its event |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Output word is the last of its event |
| out_trunc | output | 1 | Event was shortened; valid with out_last |
| discard_count | output | STAT_W | Number of dropped events, wrapping |
| trunc_count | output | STAT_W | Number of shortened events, wrapping |

## Verification
A fault in the uncommitted write pointer shows up as words of a dropped event leaking into the next kept event. Such a fault is visible at the first output word of that next event, a few cycles after its end marker. A wrong length in a descriptor moves out_last off the last word, so the next output beat of that event disagrees with the reference model in data or in the last flag. A wrong limit or counter shows at once, because the reference model compares both counters and every handshaked output word on every clock. Backpressure is applied at random so that held output words are compared against their values from the cycle before.

// File: rtl/efl_pkg.sv
`timescale 1ns/1ps
package efl_pkg;
  // Side information travelling with each word on the read side.
  typedef struct packed {
    logic last;
    logic trunc;
  } beat_tag_t;
endpackage

// File: rtl/efl_ram.sv
`timescale 1ns/1ps
module efl_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: block RAM friendly.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/efl_desc_fifo.sv
`timescale 1ns/1ps
module efl_desc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] slots [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW-1:0] == rp_q[AW-1:0]) && (wp_q[AW] != rp_q[AW]);
  assign dout  = slots[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push) slots[wp_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
    end
  end

  // R2: a descriptor is never written into a full queue nor read from an empty one.
  p_desc_room_r2: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  p_pop_valid_r2: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/efl_writer.sv
`timescale 1ns/1ps
module efl_writer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int CFG_W  = 16,
  parameter int STAT_W = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int LW    = CFG_W + 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  min_words,
  input  logic [CFG_W-1:0]  max_words,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [PW-1:0]     rd_ptr,
  output logic              ram_we,
  output logic [AW-1:0]     ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic              desc_full,
  output logic              desc_push,
  output logic [LEN_W-1:0]  desc_len,
  output logic              desc_trunc,
  output logic [STAT_W-1:0] discard_count,
  output logic [STAT_W-1:0] trunc_count
);
  logic [LW-1:0] seen_q;     // words of the open event accepted so far
  logic [PW-1:0] wp_q;       // speculative write pointer
  logic [PW-1:0] cp_q;       // last commit point
  logic [LW-1:0] limit;
  logic [LW-1:0] idx;
  logic [LW-1:0] len_now;
  logic [PW-1:0] fill;
  logic          keep_word, has_room, beat, short_ev, over;

  always_comb begin
    if (max_words == '0 || {1'b0, max_words} > LW'(DEPTH)) limit = LW'(DEPTH);
    else                                                   limit = {1'b0, max_words};
    idx       = in_sop ? '0 : seen_q;
    keep_word = idx < limit;
    len_now   = (idx == '1) ? idx : idx + 1'b1;
    fill      = wp_q - rd_ptr;
    has_room  = fill < PW'(DEPTH);
    in_ready  = !desc_full && (!keep_word || has_room);
    beat      = in_valid && in_ready;
    short_ev  = (min_words != '0) && (len_now < {1'b0, min_words});
    over      = len_now > limit;
  end

  assign ram_we     = beat && keep_word;
  assign ram_waddr  = wp_q[AW-1:0];
  assign ram_wdata  = in_data;
  assign desc_push  = beat && in_eop && !short_ev;
  assign desc_len   = keep_word ? LEN_W'(len_now) : LEN_W'(limit);
  assign desc_trunc = over;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q        <= '0;
      wp_q          <= '0;
      cp_q          <= '0;
      discard_count <= '0;
      trunc_count   <= '0;
    end else if (beat) begin
      seen_q <= in_eop ? '0 : len_now;
      if (in_eop && short_ev) begin
        wp_q          <= cp_q;
        discard_count <= discard_count + 1'b1;
      end else begin
        wp_q <= wp_q + PW'(keep_word);
        if (in_eop) begin
          cp_q <= wp_q + PW'(keep_word);
          if (over) trunc_count <= trunc_count + 1'b1;
        end
      end
    end
  end

  // R6: the store never holds more than DEPTH words (limit is clamped).
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (wp_q - rd_ptr) <= PW'(DEPTH));
  // R3: the reader never passes the commit point, so dropped words stay unread.
  p_commit_order_r3: assert property (@(posedge clk) disable iff (rst)
    (cp_q - rd_ptr) <= (wp_q - rd_ptr));
endmodule

// File: rtl/efl_reader.sv
`timescale 1ns/1ps
module efl_reader
  import efl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic              desc_trunc,
  output logic              desc_pop,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PW-1:0]     rd_ptr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_trunc
);
  localparam int OB = 2;

  logic [LEN_W-1:0]  left_q;
  logic              trunc_q;
  logic [PW-1:0]     rp_q;
  logic              pend_q;
  beat_tag_t         pend_tag_q;
  logic [DATA_W-1:0] ob_data [OB];
  beat_tag_t         ob_tag  [OB];
  logic [1:0]        ob_cnt;
  logic              ob_head;
  logic              pop, have, issue, tail;
  logic [LEN_W-1:0]  cur_left;
  beat_tag_t         cur_tag;

  always_comb begin
    pop      = out_valid && out_ready;
    have     = (left_q != '0) || desc_valid;
    issue    = have && (({1'b0, ob_cnt} + {2'b0, pend_q}) < (3'd2 + {2'b0, pop}));
    cur_left = (left_q != '0) ? left_q : desc_len;
    cur_tag.last  = (cur_left == LEN_W'(1));
    cur_tag.trunc = ((left_q != '0) ? trunc_q : desc_trunc) && cur_tag.last;
    tail     = ob_head ^ ob_cnt[0];
  end

  assign desc_pop  = issue && (left_q == '0);
  assign rd_en     = issue;
  assign rd_addr   = rp_q[AW-1:0];
  assign rd_ptr    = rp_q;
  assign out_valid = (ob_cnt != 2'd0);
  assign out_data  = ob_data[ob_head];
  assign out_last  = ob_tag[ob_head].last;
  assign out_trunc = ob_tag[ob_head].trunc;

  always_ff @(posedge clk) begin
    if (pend_q) begin
      ob_data[tail] <= rd_data;
      ob_tag[tail]  <= pend_tag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q     <= '0;
      trunc_q    <= 1'b0;
      rp_q       <= '0;
      pend_q     <= 1'b0;
      pend_tag_q <= '0;
      ob_cnt     <= '0;
      ob_head    <= 1'b0;
    end else begin
      pend_q <= issue;
      if (issue) begin
        pend_tag_q <= cur_tag;
        rp_q       <= rp_q + 1'b1;
        left_q     <= cur_left - 1'b1;
        if (left_q == '0) trunc_q <= desc_trunc;
      end
      if (pop) ob_head <= ~ob_head;
      ob_cnt <= ob_cnt + {1'b0, pend_q} - {1'b0, pop};
    end
  end

  // R7: a stalled output word is held unchanged.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_last) && $stable(out_trunc)));
  // R4: the shortened flag only rides on the closing word.
  p_trunc_last_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_trunc) |-> out_last);
  // R7: the output stage never overfills.
  p_ob_bound_r7: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, ob_cnt} + {2'b0, pend_q}) <= 3'd2);
endmodule

// File: rtl/event_size_filter.sv
`timescale 1ns/1ps
module event_size_filter #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 64,
  parameter int CFG_W      = 16,
  parameter int STAT_W     = 16,
  parameter int DESC_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  min_words,
  input  logic [CFG_W-1:0]  max_words,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_trunc,
  output logic [STAT_W-1:0] discard_count,
  output logic [STAT_W-1:0] trunc_count
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = AW + 1;
  localparam int LEN_W = $clog2(DEPTH + 1);
  localparam int DW    = LEN_W + 1;

  logic              ram_we, rd_en;
  logic [AW-1:0]     ram_waddr, rd_addr;
  logic [DATA_W-1:0] ram_wdata, rd_data;
  logic [PW-1:0]     rd_ptr;
  logic              desc_push, desc_pop, desc_full, desc_empty, desc_trunc;
  logic [LEN_W-1:0]  desc_len;
  logic [DW-1:0]     desc_out;

  efl_writer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CFG_W(CFG_W), .STAT_W(STAT_W)) u_writer (
    .clk(clk), .rst(rst), .min_words(min_words), .max_words(max_words),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .rd_ptr(rd_ptr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .desc_full(desc_full), .desc_push(desc_push), .desc_len(desc_len),
    .desc_trunc(desc_trunc), .discard_count(discard_count), .trunc_count(trunc_count)
  );

  efl_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .wr_en(ram_we), .wr_addr(ram_waddr), .wr_data(ram_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  efl_desc_fifo #(.W(DW), .DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst(rst), .push(desc_push), .din({desc_trunc, desc_len}),
    .pop(desc_pop), .dout(desc_out), .full(desc_full), .empty(desc_empty)
  );

  efl_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_reader (
    .clk(clk), .rst(rst), .desc_valid(!desc_empty),
    .desc_len(desc_out[LEN_W-1:0]), .desc_trunc(desc_out[LEN_W]),
    .desc_pop(desc_pop), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ptr(rd_ptr), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_trunc(out_trunc)
  );
endmodule

// File: tb/test_event_size_filter.sv
`timescale 1ns/1ps
module test_event_size_filter;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 64;
  localparam int CFG_W  = 16;
  localparam int STAT_W = 16;
  localparam int WD_CYC = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CFG_W-1:0]  min_words = '0;
  logic [CFG_W-1:0]  max_words = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_sop = 1'b0;
  logic              in_eop = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [DATA_W-1:0] out_data;
  logic              out_last, out_trunc;
  logic [STAT_W-1:0] discard_count, trunc_count;

  event_size_filter #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CFG_W(CFG_W), .STAT_W(STAT_W)) i_event_size_filter (
    .clk(clk), .rst(rst), .min_words(min_words), .max_words(max_words),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .out_trunc(out_trunc),
    .discard_count(discard_count), .trunc_count(trunc_count)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0, bp = 0, gaps = 0;
  string phase_req = "";
  int exp_disc = 0, exp_trunc = 0;
  logic [DATA_W-1:0] exp_d[$];
  bit exp_l[$], exp_t[$];
  string exp_r[$];
  logic [DATA_W-1:0] cur[$];
  logic [DATA_W-1:0] word_id = 32'h1000;
  bit stall_prev = 0;
  logic [DATA_W-1:0] prev_data = '0;
  bit prev_last = 0, prev_trunc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Model: decide the fate of a finished input event.
  task automatic close_event();
    int len, lim, nfw;
    bit tr;
    string tag;
    len = cur.size();
    lim = (max_words == 0 || int'(max_words) > DEPTH) ? DEPTH : int'(max_words);
    if (min_words != 0 && len < int'(min_words)) begin
      exp_disc++;
    end else begin
      tr  = len > lim;
      nfw = tr ? lim : len;
      if (tr) exp_trunc++;
      tag = (phase_req != "") ? phase_req : (tr ? "R4" : ((min_words == 0) ? "R5" : "R2"));
      for (int i = 0; i < nfw; i++) begin
        exp_d.push_back(cur[i]);
        exp_l.push_back(i == nfw - 1);
        exp_t.push_back(tr && (i == nfw - 1));
        exp_r.push_back(tag);
      end
    end
    cur.delete();
  endtask

  // Per-clock comparison against the behavioural model.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(discard_count == STAT_W'(exp_disc), "R3 discard_count", discard_count, exp_disc);
      chk(trunc_count == STAT_W'(exp_trunc), "R4 trunc_count", trunc_count, exp_trunc);
      if (stall_prev) begin
        chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
        chk(out_data == prev_data && out_last == prev_last && out_trunc == prev_trunc,
            "R7 word held", out_data, prev_data);
      end
      stall_prev = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      prev_trunc = out_trunc;
      if (out_valid && out_ready) begin
        if (exp_d.size() == 0) begin
          chk(0, "R3 unexpected output word", out_data, 0);
        end else begin
          chk(out_data == exp_d[0], {exp_r[0], " data"}, out_data, exp_d[0]);
          chk(out_last == exp_l[0], {exp_r[0], " out_last (R2)"}, out_last, exp_l[0]);
          chk(out_trunc == exp_t[0], {exp_r[0], " out_trunc (R4)"}, out_trunc, exp_t[0]);
          void'(exp_d.pop_front()); void'(exp_l.pop_front());
          void'(exp_t.pop_front()); void'(exp_r.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        if (in_sop) cur.delete();
        cur.push_back(in_data);
        if (in_eop) close_event();
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_CYC && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=%0d expected<%0d", cyc, WD_CYC);
      summary();
    end
  end

  task automatic send_event(input int len);
    for (int i = 0; i < len; i++) begin
      if (gaps && $urandom_range(0, 3) == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = word_id;
      word_id++;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain(input string req);
    while (exp_d.size() != 0) @(posedge clk);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, {req, " idle after drain"}, out_valid, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(discard_count == '0 && trunc_count == '0, "R1 counters in reset",
        {discard_count, trunc_count}, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    @(posedge clk); #1;

    // No discard, limit equals store depth.
    min_words = 0; max_words = 0;
    phase_req = "R5";
    send_event(1); send_event(3);
    phase_req = "R6";
    send_event(DEPTH); send_event(70);
    max_words = 100;
    send_event(66);
    drain("R6");
    chk(trunc_count == 2, "R6 shortened events at depth limit", trunc_count, 2);

    // Lower bound 5, upper bound 8, with backpressure.
    bp = 1; min_words = 5; max_words = 8;
    phase_req = "R8";
    send_event(4); send_event(5); send_event(8);
    phase_req = "";
    send_event(9); send_event(1); send_event(20); send_event(3);
    drain("R3");
    chk(discard_count == 3, "R3 dropped events", discard_count, 3);
    chk(trunc_count == 4, "R4 shortened events", trunc_count, 4);

    // Random lengths, gaps and backpressure.
    gaps = 1; min_words = 3; max_words = 12;
    for (int e = 0; e < 150; e++) send_event($urandom_range(1, 20));
    drain("R2");
    summary();
  end
endmodule